// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block paces one successive-approximation conversion at a time, in 8-bit or 10-bit resolution. A single timing byte sets the length of both phases. Its upper three bits give a sample count: the sample-enable output stays high for eight periods per count plus two. Its lower five bits give a conversion count: the conversion phase lasts that count times (2B - 1) periods plus three, where B is the selected resolution. One clock cycle of the block is one oscillator period. The analog input stage, the reference ladder and the comparator are outside the block. The block presents a trial code on its output bus and reads back a single comparator bit.

The conversion phase starts with three settling periods. The bits are then resolved from the most significant down. Every bit except the last is given a slot of two conversion counts, and the last bit is given one count. The comparator is read in the final period of each slot. When the last bit is decided, a signed trim value is added to the raw code. The sum is clamped to the valid range of the selected resolution and loaded into the result register, and a one-cycle done pulse is raised with it. Channel number, reference source, resolution and timing byte are all captured when a start is accepted. They hold for the whole conversion.

Top module: `sar_seq_top`

## Requirements
- R1: After a start is accepted, sample_en_o is high for exactly 8*S+2 consecutive cycles, beginning in the cycle after the accepting edge, where S = timing_i[7:5].
- R2: The conversion phase that follows sampling lasts K*(2B-1)+3 cycles, where K = timing_i[4:0], and a K of zero is run as one. The done pulse therefore appears (8*S+2)+(K*(2B-1)+3) clock edges after the accepting edge.
- R3: Bits are resolved from bit B-1 down to bit 0. The first trial code is the lone bit B-1. Each trial bit is kept when comp_hi_i is 1 (input at or above the trial level) and is dropped otherwise. trial_code_o is zero while no conversion is running.
- R4: mode10_i = 1 selects 10-bit resolution and 0 selects 8-bit. In 8-bit mode, trial codes and results use bits 7:0 and bits 9:8 stay zero.
- R5: ofs_i is a two's-complement value that is added to the raw code. The sum saturates at 0 and at full scale (255 or 1023) and never wraps.
- R6: done_o is high for exactly one cycle, on the same edge that result_o is loaded. result_o holds its value at all other times.
- R7: A start request made while a conversion is running is ignored. The running conversion keeps its timing, its result and a single done pulse, and no second conversion follows.
- R8: range_err_o is loaded when a start is accepted and holds until the next accepted start. It is set when S = 0, when K < 2, or when chan_i > 12. Such settings still run to completion.
- R9: chan_o and src_o carry chan_i and src_i as captured at the accepting edge and stay stable until the conversion ends. The src codes are 0 for the input channel, 1 for the ground reference and 2 for the full-scale reference. Timing byte and mode changes during a conversion have no effect.
- R10: While rst_n is low, sample_en_o, trial_code_o, result_o, done_o and range_err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-period clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, accepted only when idle |
| mode10_i | input | 1 | 1 = 10-bit resolution, 0 = 8-bit |
| timing_i | input | 8 | [7:5] sample count, [4:0] per-bit conversion count |
| chan_i | input | 4 | Input channel number, 0 to 12 valid |
| src_i | input | 2 | 0 channel, 1 ground reference, 2 full-scale reference |
| ofs_i | input | 5 | Signed zero-offset trim added to the result |
| comp_hi_i | input | 1 | Comparator: 1 when input is at or above trial level |
| sample_en_o | output | 1 | High during the sample phase |
| trial_code_o | output | 10 | Code presented to the reference ladder |
| chan_o | output | 4 | Captured channel number for the input multiplexer |
| src_o | output | 2 | Captured source selection |
| result_o | output | 10 | Offset-adjusted, saturated result |
| done_o | output | 1 | One-cycle pulse when result_o updates |
| range_err_o | output | 1 | Timing byte or channel out of its valid range |

## Verification
A wrong phase counter moves the done pulse away from the edge that the timing formula predicts. It also changes the number of cycles sample_en_o is high, so the error shows within one conversion. A wrong approximation register shows in the first trial code, or in a result that does not equal the clipped input level. A misbehaving saturation stage shows only at the extreme trim values, so the vectors drive the sum past both ends of the range. Captured configuration that leaks shows either as a selection that moves during a run or as a changed latency when a second start arrives mid-conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SAMP = 2'd1,
      PH_SETL = 2'd2,
      PH_BITS = 2'd3
   } phase_e;

   localparam int unsigned SETTLE_CYCLES = 3;
   localparam int unsigned SAMP_STEP     = 8;
   localparam int unsigned SAMP_BASE     = 2;

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
   import sar_seq_pkg::*;
#(
   parameter int RES_HI = 10,
   parameter int RES_LO = 8,
   parameter int SAM_W  = 3,
   parameter int CONV_W = 5,
   parameter int CNT_W  = 7,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              mode10_i,
   input  logic [SAM_W-1:0]  sam_i,
   input  logic [CONV_W-1:0] conv_i,
   output logic              busy_o,
   output logic              sample_o,
   output logic              bits_o,
   output logic              tick_o,
   output logic              last_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              mode10_o
);

   phase_e            ph_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [CONV_W-1:0] conv_q;
   logic              mode_q;

   logic [CNT_W-1:0]  conv_eff;
   logic [CNT_W-1:0]  slot_full;
   logic [CNT_W-1:0]  slot_last;
   logic [CNT_W-1:0]  samp_load;
   logic [IDX_W-1:0]  idx_top;

   always_comb begin
      conv_eff  = (conv_q == '0) ? CNT_W'(1) : CNT_W'(conv_q);
      slot_full = (conv_eff << 1) - CNT_W'(1);
      slot_last = conv_eff - CNT_W'(1);
      samp_load = CNT_W'(SAMP_STEP) * CNT_W'(sam_i) + CNT_W'(SAMP_BASE - 1);
      idx_top   = mode_q ? IDX_W'(RES_HI - 1) : IDX_W'(RES_LO - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         conv_q <= '0;
         mode_q <= 1'b0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (accept_i) begin
                  ph_q   <= PH_SAMP;
                  cnt_q  <= samp_load;
                  conv_q <= conv_i;
                  mode_q <= mode10_i;
               end
            end
            PH_SAMP: begin
               if (cnt_q == '0) begin
                  ph_q  <= PH_SETL;
                  cnt_q <= CNT_W'(SETTLE_CYCLES - 1);
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_SETL: begin
               if (cnt_q == '0) begin
                  ph_q  <= PH_BITS;
                  idx_q <= idx_top;
                  cnt_q <= slot_full;
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            PH_BITS: begin
               if (cnt_q == '0) begin
                  if (idx_q == '0) begin
                     ph_q <= PH_IDLE;
                  end else begin
                     idx_q <= idx_q - IDX_W'(1);
                     cnt_q <= (idx_q == IDX_W'(1)) ? slot_last : slot_full;
                  end
               end else begin
                  cnt_q <= cnt_q - CNT_W'(1);
               end
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy_o   = (ph_q != PH_IDLE);
   assign sample_o = (ph_q == PH_SAMP);
   assign bits_o   = (ph_q == PH_BITS);
   assign tick_o   = bits_o && (cnt_q == '0);
   assign last_o   = tick_o && (idx_q == '0);
   assign idx_o    = idx_q;
   assign mode10_o = mode_q;

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
   parameter int RES_HI = 10,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              active_i,
   input  logic              tick_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic              comp_i,
   output logic [RES_HI-1:0] trial_o,
   output logic [RES_HI-1:0] decided_o
);

   logic [RES_HI-1:0] sar_q;
   logic [RES_HI-1:0] mask;

   for (genvar g = 0; g < RES_HI; g++) begin : g_mask
      assign mask[g] = (idx_i == IDX_W'(g));
   end

   assign trial_o   = active_i ? (sar_q | mask) : '0;
   assign decided_o = comp_i ? (sar_q | mask) : sar_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sar_q <= '0;
      end else if (clear_i) begin
         sar_q <= '0;
      end else if (tick_i) begin
         sar_q <= decided_o;
      end
   end

endmodule

// File: rtl/sar_offset_sat.sv
module sar_offset_sat #(
   parameter int RES_HI = 10,
   parameter int RES_LO = 8,
   parameter int OFS_W  = 5
) (
   input  logic [RES_HI-1:0]       raw_i,
   input  logic signed [OFS_W-1:0] ofs_i,
   input  logic                    mode10_i,
   output logic [RES_HI-1:0]       res_o
);

   localparam int SUM_W = RES_HI + 2;
   localparam logic [RES_HI-1:0] FULL_HI = {RES_HI{1'b1}};
   localparam logic [RES_HI-1:0] FULL_LO = RES_HI'((1 << RES_LO) - 1);

   logic signed [SUM_W-1:0] sum;
   logic signed [SUM_W-1:0] full_s;
   logic [RES_HI-1:0]       full;

   always_comb begin
      full   = mode10_i ? FULL_HI : FULL_LO;
      full_s = $signed({2'b00, full});
      sum    = $signed({2'b00, raw_i}) + SUM_W'(ofs_i);
      if (sum < 0) begin
         res_o = '0;
      end else if (sum > full_s) begin
         res_o = full;
      end else begin
         res_o = sum[RES_HI-1:0];
      end
   end

endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
   parameter int RES_HI   = 10,
   parameter int RES_LO   = 8,
   parameter int TBYTE_W  = 8,
   parameter int SAM_W    = 3,
   parameter int OFS_W    = 5,
   parameter int CHAN_W   = 4,
   parameter int NUM_CHAN = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                mode10_i,
   input  logic [TBYTE_W-1:0]  timing_i,
   input  logic [CHAN_W-1:0]   chan_i,
   input  logic [1:0]          src_i,
   input  logic [OFS_W-1:0]    ofs_i,
   input  logic                comp_hi_i,
   output logic                sample_en_o,
   output logic [RES_HI-1:0]   trial_code_o,
   output logic [CHAN_W-1:0]   chan_o,
   output logic [1:0]          src_o,
   output logic [RES_HI-1:0]   result_o,
   output logic                done_o,
   output logic                range_err_o
);

   localparam int CONV_W   = TBYTE_W - SAM_W;
   localparam int CONV_MAX = (1 << CONV_W) - 1;
   localparam int SAM_MAX  = (1 << SAM_W) - 1;
   localparam int CNT_W    = $clog2(2 * CONV_MAX + 8 * SAM_MAX + 3);
   localparam int IDX_W    = $clog2(RES_HI);

   if (RES_LO >= RES_HI) begin : g_bad_res
      $error("RES_LO must be below RES_HI");
   end
   if (OFS_W >= RES_LO) begin : g_bad_ofs
      $error("OFS_W must be below RES_LO");
   end
   if (NUM_CHAN > (1 << CHAN_W)) begin : g_bad_chan
      $error("NUM_CHAN does not fit CHAN_W");
   end
   if (SAM_W >= TBYTE_W) begin : g_bad_tbyte
      $error("SAM_W must leave room for the conversion count");
   end

   logic [SAM_W-1:0]  sam;
   logic [CONV_W-1:0] conv;
   logic              busy;
   logic              accept;
   logic              bits_act;
   logic              tick;
   logic              last;
   logic [IDX_W-1:0]  idx;
   logic              mode10_q;
   logic [RES_HI-1:0] decided;
   logic [RES_HI-1:0] adjusted;

   logic [RES_HI-1:0] result_q;
   logic              done_q;
   logic              range_q;
   logic [CHAN_W-1:0] chan_q;
   logic [1:0]        src_q;

   assign sam    = timing_i[TBYTE_W-1 -: SAM_W];
   assign conv   = timing_i[CONV_W-1:0];
   assign accept = start_i && !busy;

   sar_phase_ctrl #(
      .RES_HI (RES_HI),
      .RES_LO (RES_LO),
      .SAM_W  (SAM_W),
      .CONV_W (CONV_W),
      .CNT_W  (CNT_W),
      .IDX_W  (IDX_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .mode10_i (mode10_i),
      .sam_i    (sam),
      .conv_i   (conv),
      .busy_o   (busy),
      .sample_o (sample_en_o),
      .bits_o   (bits_act),
      .tick_o   (tick),
      .last_o   (last),
      .idx_o    (idx),
      .mode10_o (mode10_q)
   );

   sar_approx_reg #(
      .RES_HI (RES_HI),
      .IDX_W  (IDX_W)
   ) u_sar (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (accept),
      .active_i  (bits_act),
      .tick_i    (tick),
      .idx_i     (idx),
      .comp_i    (comp_hi_i),
      .trial_o   (trial_code_o),
      .decided_o (decided)
   );

   sar_offset_sat #(
      .RES_HI (RES_HI),
      .RES_LO (RES_LO),
      .OFS_W  (OFS_W)
   ) u_sat (
      .raw_i    (decided),
      .ofs_i    ($signed(ofs_i)),
      .mode10_i (mode10_q),
      .res_o    (adjusted)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         done_q   <= 1'b0;
         range_q  <= 1'b0;
         chan_q   <= '0;
         src_q    <= '0;
      end else begin
         done_q <= last;
         if (last) begin
            result_q <= adjusted;
         end
         if (accept) begin
            chan_q  <= chan_i;
            src_q   <= src_i;
            range_q <= (sam == '0) || (conv < CONV_W'(2)) ||
                       (chan_i >= CHAN_W'(NUM_CHAN));
         end
      end
   end

   assign result_o    = result_q;
   assign done_o      = done_q;
   assign range_err_o = range_q;
   assign chan_o      = chan_q;
   assign src_o       = src_q;

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int RES_HI = 10,
   parameter int RES_LO = 8,
   parameter int CHAN_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy,
   input logic              mode10_q,
   input logic              sample_en_o,
   input logic [RES_HI-1:0] trial_code_o,
   input logic [CHAN_W-1:0] chan_o,
   input logic [1:0]        src_o,
   input logic [RES_HI-1:0] result_o,
   input logic              done_o
);

   // R1: sampling begins as soon as a conversion begins
   a_r1_sample_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> sample_en_o);

   // R1: sampling only inside a running conversion
   a_r1_sample_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      sample_en_o |-> busy);

   // R3: no trial code while idle
   a_r3_trial_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (trial_code_o == '0));

   // R4: narrow mode leaves upper trial bits clear
   a_r4_narrow_trial: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mode10_q) |-> (trial_code_o[RES_HI-1:RES_LO] == '0));

   // R5: narrow-mode result never exceeds its full scale
   a_r5_narrow_result: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !mode10_q) |-> (result_o[RES_HI-1:RES_LO] == '0));

   // R6: done is a single-cycle pulse
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: result only moves with done
   a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(result_o));

   // R6: done marks the end of a conversion
   a_r6_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $fell(busy));

   // R7: a start during a run neither aborts nor restarts it
   a_r7_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start_i) |=> (busy || done_o));

   // R9: captured selection holds during a run
   a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(chan_o) && $stable(src_o)));

endmodule

bind sar_seq_top sar_seq_chk #(
   .RES_HI (RES_HI),
   .RES_LO (RES_LO),
   .CHAN_W (CHAN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .busy         (busy),
   .mode10_q     (mode10_q),
   .sample_en_o  (sample_en_o),
   .trial_code_o (trial_code_o),
   .chan_o       (chan_o),
   .src_o        (src_o),
   .result_o     (result_o),
   .done_o       (done_o)
);

// File: tb/sar_seq_top_tb.sv
module sar_seq_top_tb;

   localparam int CLK_P = 10;
   localparam int NVEC  = 11;

   // {mode10, timing, level, trim, chan, src}
   localparam logic [29:0] VEC [NVEC] = '{
      {1'b1, 8'h22, 10'h2A5, 5'd0,  4'd3,  2'd0},
      {1'b0, 8'h43, 10'h05C, 5'd3,  4'd0,  2'd0},
      {1'b1, 8'hE2, 10'h3FF, 5'd5,  4'd12, 2'd0},
      {1'b0, 8'h22, 10'h002, 5'h1A, 4'd5,  2'd0},
      {1'b0, 8'h01, 10'h080, 5'd0,  4'd1,  2'd0},
      {1'b1, 8'h60, 10'h155, 5'h1F, 4'd2,  2'd0},
      {1'b0, 8'h25, 10'h3FF, 5'd0,  4'd7,  2'd0},
      {1'b1, 8'h3F, 10'h000, 5'd0,  4'd4,  2'd0},
      {1'b1, 8'h22, 10'h1F0, 5'd2,  4'd6,  2'd1},
      {1'b0, 8'h22, 10'h000, 5'h1E, 4'd6,  2'd2},
      {1'b1, 8'h22, 10'h100, 5'd0,  4'd13, 2'd0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       mode10_i = 1'b0;
   logic [7:0] timing_i = '0;
   logic [3:0] chan_i = '0;
   logic [1:0] src_i = '0;
   logic [4:0] ofs_i = '0;
   logic       comp_hi_i;
   logic       sample_en_o;
   logic [9:0] trial_code_o;
   logic [3:0] chan_o;
   logic [1:0] src_o;
   logic [9:0] result_o;
   logic       done_o;
   logic       range_err_o;

   logic [9:0] level = '0;
   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   always_comb begin
      case (src_o)
         2'd1:    comp_hi_i = 1'b0;
         2'd2:    comp_hi_i = 1'b1;
         default: comp_hi_i = (level >= trial_code_o);
      endcase
   end

   sar_seq_top u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .mode10_i     (mode10_i),
      .timing_i     (timing_i),
      .chan_i       (chan_i),
      .src_i        (src_i),
      .ofs_i        (ofs_i),
      .comp_hi_i    (comp_hi_i),
      .sample_en_o  (sample_en_o),
      .trial_code_o (trial_code_o),
      .chan_o       (chan_o),
      .src_o        (src_o),
      .result_o     (result_o),
      .done_o       (done_o),
      .range_err_o  (range_err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_conv(input logic [29:0] v, input bit mid_start);
      bit   m     = v[29];
      int   sam   = int'(v[28:26]);
      int   conv  = int'(v[25:21]);
      int   lvl   = int'(v[20:11]);
      int   ofs   = int'($signed(v[10:6]));
      int   ch    = int'(v[5:2]);
      int   src   = int'(v[1:0]);
      int   b     = m ? 10 : 8;
      int   full  = m ? 1023 : 255;
      int   ceff  = (conv == 0) ? 1 : conv;
      int   lat   = (8 * sam + 2) + (ceff * (2 * b - 1) + 3);
      int   raw;
      int   expv;
      int   n     = 0;
      int   samp  = 0;
      int   first = 0;
      bit   upper_bad = 1'b0;
      bit   sel_bad   = 1'b0;
      bit   got_done  = 1'b0;
      raw = (src == 1) ? 0 : (src == 2) ? full : ((lvl > full) ? full : lvl);
      expv = raw + ofs;
      if (expv < 0) expv = 0;
      if (expv > full) expv = full;

      @(negedge clk);
      mode10_i = m; timing_i = v[28:21]; level = v[20:11];
      ofs_i = v[10:6]; chan_i = v[5:2]; src_i = v[1:0];
      start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      chan_i = ~chan_i; src_i = 2'd3;
      if (sample_en_o) samp++;
      while (n < 2000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (mid_start && n == 5) begin
            start_i = 1'b1; timing_i = 8'hFF; mode10_i = ~m;
         end
         if (mid_start && n == 6) start_i = 1'b0;
         if (sample_en_o) samp++;
         if (first == 0 && trial_code_o != '0) first = int'(trial_code_o);
         if (!m && trial_code_o[9:8] != 2'b00) upper_bad = 1'b1;
         if (chan_o != v[5:2] || src_o != v[1:0]) sel_bad = 1'b1;
         if (done_o) begin
            got_done = 1'b1;
            break;
         end
      end
      chk(got_done, "R2 done seen", int'(got_done), 1);
      chk(n == lat, "R2 latency", n, lat);
      chk(samp == 8 * sam + 2, "R1 sample length", samp, 8 * sam + 2);
      chk(first == (1 << (b - 1)), "R3 first trial", first, 1 << (b - 1));
      chk(int'(result_o) == expv, "R5 result", int'(result_o), expv);
      chk(!upper_bad, "R4 narrow trial", int'(upper_bad), 0);
      chk(!sel_bad, "R9 selection held", int'(sel_bad), 0);
      chk(int'(range_err_o) == int'(sam == 0 || conv < 2 || ch > 12),
          "R8 range flag", int'(range_err_o), int'(sam == 0 || conv < 2 || ch > 12));
      @(posedge clk);
      @(negedge clk);
      chk(!done_o, "R6 done one cycle", int'(done_o), 0);
      chk(int'(result_o) == expv, "R6 result held", int'(result_o), expv);
      chk(!sample_en_o, "R7 no queued start", int'(sample_en_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(!sample_en_o && !done_o && !range_err_o, "R10 reset flags",
          int'({sample_en_o, done_o, range_err_o}), 0);
      chk(result_o == '0 && trial_code_o == '0, "R10 reset data",
          int'(result_o) + int'(trial_code_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         run_conv(VEC[i], 1'b0);
      end

      // R7: second start with changed timing and mode mid-run is ignored
      run_conv(VEC[0], 1'b1);
      run_conv(VEC[1], 1'b1);

      // R8: flag holds until next accepted start, then clears
      run_conv(VEC[4], 1'b0);
      repeat (5) @(negedge clk);
      chk(range_err_o, "R8 flag held", int'(range_err_o), 1);
      run_conv(VEC[1], 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule